// File: doc/BRIEF.md
# Parking occupancy up/down counter

This block tracks how many vehicles are inside a car park with one up/down counter. Sensors upstream deliver single-cycle strobes: an arrival strobe for each vehicle that drives in and a departure strobe for each one that drives out. The block turns the history of those strobes into a present occupancy figure and drives a FULL indicator for a sign.

A static mode input selects how arrivals at capacity are treated. In gated mode a barrier is assumed: the count stops at the capacity, further arrivals are refused, and FULL is lit exactly while the count sits at capacity. In gateless mode nothing can stop a car, so every arrival is counted in extra counter bits above capacity. FULL then lights when the count climbs past capacity and clears only once it drops below capacity, so it holds its last value while the count equals capacity. The capacity and the amount of headroom are parameters. The mode is meant to change only while reset is held.

Top module: `lot_occupancy`

## Requirements
- R1: A synchronous active-high reset drives the count to 0 and FULL to 0.
- R2: An arrival strobe without a departure strobe raises the count by one, and a departure strobe without an arrival strobe lowers it by one; the new count appears after the rising clock edge that samples the strobe.
- R3: A departure strobe while the count is 0 is ignored and the count stays 0 in both modes.
- R4: In gated mode (mode input 0) an arrival strobe while the count equals CAPACITY is refused, and the count never exceeds CAPACITY.
- R5: In gated mode FULL is 1 exactly when the count equals CAPACITY, and it changes on the same clock edge as the count.
- R6: In gateless mode (mode input 1) arrivals are accepted above CAPACITY and each raises the count by one.
- R7: In gateless mode FULL is 1 whenever the count is above CAPACITY.
- R8: In gateless mode FULL is 0 whenever the count is below CAPACITY, and while the count equals CAPACITY FULL keeps the value it had on the previous cycle (0 when reached from below, 1 when reached from above).
- R9: Arrival and departure strobes in the same cycle cancel: the count and FULL stay unchanged, also at 0, at CAPACITY and at the top of the range.
- R10: The count is ceil(log2(CAPACITY+1)) + EXTRA_BITS bits wide; in gateless mode it saturates at the all-ones value of that width, ignoring further arrivals instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = gated, 1 = gateless; static outside reset |
| enter_i | input | 1 | One-cycle strobe per arriving vehicle |
| leave_i | input | 1 | One-cycle strobe per departing vehicle |
| count_o | output | CNT_W | Present occupancy count |
| full_o | output | 1 | FULL indicator |

## Verification
The bench drives departures at an empty lot, where a design lacking the floor would wrap to the top of the range, and arrivals at capacity in gated mode, where a missing limit would let the count reach CAPACITY+1 and drop FULL. In gateless mode it walks the count up through capacity, over it and back, so a FULL flag without hysteresis would show 1 at capacity on the way up or 0 at capacity on the way down, and it pushes arrivals at the all-ones value, where a wrapping counter would return to 0. Simultaneous strobes are applied at every limit, catching a design that lets one strobe win.

// File: rtl/lotcnt_pkg.sv
package lotcnt_pkg;

   typedef enum logic {
      MODE_GATED    = 1'b0,
      MODE_GATELESS = 1'b1
   } lot_mode_e;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

endpackage

// File: rtl/lot_step_decode.sv
module lot_step_decode
   import lotcnt_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int CAPACITY = 6
) (
   input  lot_mode_e         mode_i,
   input  logic              enter_i,
   input  logic              leave_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output step_e             step_o
);

   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);
   localparam logic [CNT_W-1:0] TOP_V = '1;

   logic at_ceiling;
   logic at_floor;

   always_comb begin
      if (mode_i == MODE_GATED) begin
         at_ceiling = (cnt_i >= CAP_V);
      end else begin
         at_ceiling = (cnt_i == TOP_V);
      end
      at_floor = (cnt_i == '0);
   end

   always_comb begin
      step_o = STEP_HOLD;
      if (enter_i && !leave_i && !at_ceiling) begin
         step_o = STEP_UP;
      end else if (leave_i && !enter_i && !at_floor) begin
         step_o = STEP_DOWN;
      end
   end

endmodule

// File: rtl/lot_count_reg.sv
module lot_count_reg
   import lotcnt_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  step_e             step_i,
   output logic [CNT_W-1:0]  cnt_q_o,
   output logic [CNT_W-1:0]  cnt_d_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_comb begin
      case (step_i)
         STEP_UP:   cnt_d_o = cnt_q_o + ONE;
         STEP_DOWN: cnt_d_o = cnt_q_o - ONE;
         default:   cnt_d_o = cnt_q_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q_o <= '0;
      end else begin
         cnt_q_o <= cnt_d_o;
      end
   end

   // R2: an accepted step moves the register by exactly one
   p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
      (step_i == STEP_UP) |=> (cnt_q_o == $past(cnt_q_o) + ONE));

   p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
      (step_i == STEP_DOWN) |=> (cnt_q_o == $past(cnt_q_o) - ONE));

endmodule

// File: rtl/lot_full_flag.sv
module lot_full_flag
   import lotcnt_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int CAPACITY = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  lot_mode_e         mode_i,
   input  logic [CNT_W-1:0]  cnt_d_i,
   output logic              full_o
);

   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

   logic full_d;

   always_comb begin
      if (mode_i == MODE_GATED) begin
         full_d = (cnt_d_i == CAP_V);
      end else if (cnt_d_i > CAP_V) begin
         full_d = 1'b1;
      end else if (cnt_d_i < CAP_V) begin
         full_d = 1'b0;
      end else begin
         full_d = full_o;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         full_o <= 1'b0;
      end else begin
         full_o <= full_d;
      end
   end

endmodule

// File: rtl/lot_occupancy.sv
module lot_occupancy
   import lotcnt_pkg::*;
#(
   parameter int CAPACITY   = 6,
   parameter int EXTRA_BITS = 1,
   localparam int BASE_W    = $clog2(CAPACITY + 1),
   localparam int CNT_W     = BASE_W + EXTRA_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_i,
   input  logic              enter_i,
   input  logic              leave_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              full_o
);

   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);
   localparam logic [CNT_W-1:0] TOP_V = '1;

   generate
      if (CAPACITY < 1) begin : g_bad_capacity
         $error("lot_occupancy: CAPACITY must be at least 1");
      end
      if (EXTRA_BITS < 1) begin : g_bad_headroom
         $error("lot_occupancy: EXTRA_BITS must be at least 1");
      end
   endgenerate

   lot_mode_e mode;
   step_e     step;
   logic [CNT_W-1:0] cnt_d;

   assign mode = lot_mode_e'(mode_i);

   lot_step_decode #(.CNT_W(CNT_W), .CAPACITY(CAPACITY)) u_decode (
      .mode_i  (mode),
      .enter_i (enter_i),
      .leave_i (leave_i),
      .cnt_i   (count_o),
      .step_o  (step)
   );

   lot_count_reg #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step),
      .cnt_q_o (count_o),
      .cnt_d_o (cnt_d)
   );

   lot_full_flag #(.CNT_W(CNT_W), .CAPACITY(CAPACITY)) u_full (
      .clk     (clk),
      .rst     (rst),
      .mode_i  (mode),
      .cnt_d_i (cnt_d),
      .full_o  (full_o)
   );

   // R3: departures at an empty lot leave it empty
   p_floor_r3: assert property (@(posedge clk) disable iff (rst)
      (count_o == '0 && leave_i && !enter_i) |=> (count_o == '0));

   // R4: gated count never passes capacity
   p_gated_cap_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 1'b0) |-> (count_o <= CAP_V));

   // R5: gated FULL tracks the count register
   p_gated_full_r5: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 1'b0) |-> (full_o == (count_o == CAP_V)));

   // R7: gateless FULL lit above capacity
   p_gl_over_r7: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 1'b1 && count_o > CAP_V) |-> full_o);

   // R8: gateless FULL dark below capacity, held at capacity
   p_gl_under_r8: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 1'b1 && count_o < CAP_V) |-> !full_o);

   p_gl_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 1'b1 && count_o == CAP_V && $past(count_o) == CAP_V) |-> $stable(full_o));

   // R9: simultaneous strobes cancel
   p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
      (enter_i && leave_i) |=> ($stable(count_o) && $stable(full_o)));

   // R10: gateless count saturates at the top of its range
   p_gl_top_r10: assert property (@(posedge clk) disable iff (rst)
      (mode_i == 1'b1 && count_o == TOP_V && enter_i && !leave_i) |=> (count_o == TOP_V));

endmodule

// File: tb/sim_lot_occupancy.sv
module sim_lot_occupancy;

   localparam int CAPACITY   = 6;
   localparam int EXTRA_BITS = 1;
   localparam int CNT_W      = $clog2(CAPACITY + 1) + EXTRA_BITS;
   localparam int TOP        = (1 << CNT_W) - 1;

   typedef struct {
      int    cnt;
      bit    full;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode_i = 1'b0;
   logic enter_i = 1'b0;
   logic leave_i = 1'b0;
   logic [CNT_W-1:0] count_o;
   logic full_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   exp_t q[$];

   int m_cnt = 0;
   bit m_full = 1'b0;

   always #2.5 clk = ~clk;

   lot_occupancy #(.CAPACITY(CAPACITY), .EXTRA_BITS(EXTRA_BITS)) u0 (
      .clk     (clk),
      .rst     (rst),
      .mode_i  (mode_i),
      .enter_i (enter_i),
      .leave_i (leave_i),
      .count_o (count_o),
      .full_o  (full_o)
   );

   task automatic do_reset(bit m);
      @(negedge clk);
      rst = 1'b1;
      enter_i = 1'b0;
      leave_i = 1'b0;
      mode_i = m;
      repeat (3) @(negedge clk);
      m_cnt = 0;
      m_full = 1'b0;
      total++;
      if (int'(count_o) != 0 || full_o !== 1'b0) begin
         bad++;
         $display("FAIL R1: count=%0d full=%0b expected count=0 full=0", count_o, full_o);
      end
      rst = 1'b0;
   endtask

   task automatic drive(bit e, bit l, string tag);
      int limit;
      exp_t item;
      @(negedge clk);
      enter_i = e;
      leave_i = l;
      limit = mode_i ? TOP : CAPACITY;
      if (e && !l && m_cnt < limit) m_cnt++;
      else if (l && !e && m_cnt > 0) m_cnt--;
      if (!mode_i) m_full = (m_cnt == CAPACITY);
      else if (m_cnt > CAPACITY) m_full = 1'b1;
      else if (m_cnt < CAPACITY) m_full = 1'b0;
      item.cnt = m_cnt;
      item.full = m_full;
      item.tag = tag;
      q.push_back(item);
   endtask

   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (int'(count_o) != e.cnt || full_o !== e.full) begin
               bad++;
               $display("FAIL %s: count=%0d full=%0b expected count=%0d full=%0b",
                        e.tag, count_o, full_o, e.cnt, e.full);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog: run did not finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // gated mode
      do_reset(1'b0);
      drive(0, 1, "R3");
      drive(0, 1, "R3");
      drive(1, 1, "R9");
      for (int i = 0; i < CAPACITY - 1; i++) drive(1, 0, "R2");
      drive(1, 0, "R5");
      drive(1, 0, "R4");
      drive(1, 0, "R4");
      drive(1, 1, "R9");
      drive(0, 1, "R5");
      drive(1, 0, "R5");
      for (int i = 0; i < CAPACITY; i++) drive(0, 1, "R2");
      drive(1, 1, "R9");
      drive(0, 1, "R3");
      drive(0, 0, "R2");

      // gateless mode
      do_reset(1'b1);
      drive(0, 1, "R3");
      for (int i = 0; i < CAPACITY; i++) drive(1, 0, "R8");
      drive(1, 1, "R9");
      drive(1, 0, "R7");
      drive(1, 0, "R6");
      drive(0, 1, "R7");
      drive(0, 1, "R8");
      drive(1, 1, "R9");
      drive(0, 1, "R8");
      drive(1, 0, "R8");
      for (int i = CAPACITY; i < TOP; i++) drive(1, 0, "R6");
      drive(1, 0, "R10");
      drive(1, 0, "R10");
      drive(1, 1, "R9");
      drive(0, 1, "R7");
      drive(0, 0, "R10");

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule